// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

A 16-bit up-counter runs while enabled and serves two channels. Each channel is set through an option bit to work either as a capture register, which stores the count when a chosen edge shows up on its input pin, or as a compare register, which pulses an interrupt and inverts its output pin one count after the programmed value. The counter advances on a per-cycle internal enable, or on chosen edges of an external event input when that source is selected.

Software reaches the block through a word-wide register port with a one-cycle read latency. Pin inputs pass through a two-stage synchronizer before edge detection. A sticky overflow flag records each wrap from 0xFFFF to 0x0000.

Top module: `cct_timer`

## Requirements
- R1: After reset every register, the counter, `rdata_o`, `irq_o` and `tout_o` are zero. Register addresses: 0 control, 1 capture edge select, 2 event edge select, 3 option, 4 counter (read-only), 5 channel 0, 6 channel 1, 7 reads zero.
- R2: With control bit 0 (run) set, the counter adds one on each count tick and holds otherwise. A read with `re_i` high at a clock edge presents the register value on `rdata_o` after that edge.
- R3: Option bit 0 is set when the counter wraps from 0xFFFF to 0x0000. It stays set until a write to the option register with bit 0 at 0. Writing 1 has no effect. A wrap and a clearing write in the same cycle leave it set.
- R4: A channel in compare mode holding value D pulses its `irq_o` bit for one cycle and inverts its `tout_o` bit at the edge where the counter steps from D to D+1. D = 0xFFFF matches on the wrap to 0x0000.
- R5: A channel in capture mode stores the count on a selected edge of its `cap_i` bit and pulses its `irq_o` bit in the same cycle. This happens at the third clock edge after the pin changes.
- R6: Every 2-bit edge field is coded 00 none, 01 rising, 10 falling, 11 both. Channel 0 uses capture edge select bits 1:0, and channel 1 uses bits 3:2. The event input uses event edge select bits 1:0.
- R7: Option bit 4 (channel 0) and bit 5 (channel 1) select capture mode at 1 and compare mode at 0. A channel in compare mode ignores its `cap_i` edges.
- R8: With control bit 1 set, the count tick is a selected edge of `evt_i` and `tick_i` is ignored.
- R9: With run clear, the counter goes to zero and `irq_o` and `tout_o` are driven low from the next cycle on.
- R10: A read of a channel register in the cycle it captures returns the value it held before the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 1 | internal count enable |
| cap_i | input | 2 | capture pins, one per channel |
| evt_i | input | 1 | external event count pin |
| addr_i | input | 3 | register address |
| we_i | input | 1 | register write strobe |
| re_i | input | 1 | register read strobe |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data, one cycle after `re_i` |
| irq_o | output | 2 | per-channel capture/compare pulse |
| tout_o | output | 2 | per-channel compare toggle output |

## Verification
Register reads are due one edge after the strobe. The scoreboard queues each expected word when the read is issued and pops it at the falling edge after the next rising edge. A compare pulse is due at the edge where the counter reaches D+1, so the bench counts edges from the run write and samples each cycle at the falling edge. Capture and event edges are due three edges after a pin change, and the bench samples the capture pulse at exactly the third falling edge. It places the competing read on that same edge and waits at least four cycles before reading a captured value or the counter.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAPSEL = 3'd1;
  localparam logic [ADDR_W-1:0] A_EVTSEL = 3'd2;
  localparam logic [ADDR_W-1:0] A_OPT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT    = 3'd4;
  localparam logic [ADDR_W-1:0] A_CC0    = 3'd5;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_EXT = 1;
  localparam int unsigned OPT_OVF  = 0;
  localparam int unsigned OPT_MODE = 4;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (!run_i) cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = run_i & tick_i & (&cnt_o);
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         cap_mode_i,
  input  logic         cap_hit_i,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cc_o,
  output logic         irq_o,
  output logic         tout_o
);
  logic do_cap, do_cmp;

  assign do_cap = run_i & cap_mode_i & cap_hit_i;
  // match one count early so the event lands as the counter reaches D+1
  assign do_cmp = run_i & ~cap_mode_i & tick_i & (cnt_i == cc_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cc_o <= '0;
    else if (do_cap) cc_o <= cnt_i;
    else if (wr_i)   cc_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      tout_o <= 1'b0;
    end else if (!run_i) begin
      irq_o  <= 1'b0;
      tout_o <= 1'b0;
    end else begin
      irq_o <= do_cap | do_cmp;
      if (do_cmp) tout_o <= ~tout_o;
    end
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [N_CH-1:0]          cap_i,
  input  logic                     evt_i,
  input  logic [cct_pkg::ADDR_W-1:0] addr_i,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [CNT_W-1:0]         wdata_i,
  output logic [CNT_W-1:0]         rdata_o,
  output logic [N_CH-1:0]          irq_o,
  output logic [N_CH-1:0]          tout_o
);
  import cct_pkg::*;

  localparam int unsigned SEL_W = 2 * N_CH;
  localparam int unsigned PIN_W = N_CH + 1;

  logic              run_q, ext_q, ovf_q;
  logic [SEL_W-1:0]  capsel_q;
  logic [1:0]        evtsel_q;
  logic [N_CH-1:0]   mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cc_q [N_CH];
  logic [PIN_W-1:0]  pin_rise, pin_fall;
  logic              evt_hit, src_tick, cnt_tick, wrap;
  logic              wr_ctrl, wr_capsel, wr_evtsel, wr_opt;
  logic [CNT_W-1:0]  rd_val;

  assign wr_ctrl   = we_i && (addr_i == A_CTRL);
  assign wr_capsel = we_i && (addr_i == A_CAPSEL);
  assign wr_evtsel = we_i && (addr_i == A_EVTSEL);
  assign wr_opt    = we_i && (addr_i == A_OPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ext_q    <= 1'b0;
      capsel_q <= '0;
      evtsel_q <= '0;
      mode_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata_i[CTRL_RUN];
        ext_q <= wdata_i[CTRL_EXT];
      end
      if (wr_capsel) capsel_q <= wdata_i[SEL_W-1:0];
      if (wr_evtsel) evtsel_q <= wdata_i[1:0];
      if (wr_opt)    mode_q   <= wdata_i[OPT_MODE +: N_CH];
    end
  end

  // wrap outranks a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovf_q <= 1'b0;
    else if (wrap)                        ovf_q <= 1'b1;
    else if (wr_opt && !wdata_i[OPT_OVF]) ovf_q <= 1'b0;
  end

  cct_sync_edge #(.W(PIN_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({evt_i, cap_i}),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign evt_hit  = edge_hit(evtsel_q, pin_rise[N_CH], pin_fall[N_CH]);
  assign src_tick = ext_q ? evt_hit : tick_i;
  assign cnt_tick = run_q & src_tick;

  cct_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_i (cnt_tick),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic cap_hit, cc_wr;
    assign cap_hit = edge_hit(capsel_q[2*i +: 2], pin_rise[i], pin_fall[i]);
    assign cc_wr   = we_i && (addr_i == A_CC0 + ADDR_W'(i));

    cct_channel #(.W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q),
      .cap_mode_i (mode_q[i]),
      .cap_hit_i  (cap_hit),
      .tick_i     (cnt_tick),
      .cnt_i      (cnt_q),
      .wr_i       (cc_wr),
      .wdata_i    (wdata_i),
      .cc_o       (cc_q[i]),
      .irq_o      (irq_o[i]),
      .tout_o     (tout_o[i])
    );
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      A_CTRL: begin
        rd_val[CTRL_RUN] = run_q;
        rd_val[CTRL_EXT] = ext_q;
      end
      A_CAPSEL: rd_val[SEL_W-1:0] = capsel_q;
      A_EVTSEL: rd_val[1:0]       = evtsel_q;
      A_OPT: begin
        rd_val[OPT_OVF]           = ovf_q;
        rd_val[OPT_MODE +: N_CH]  = mode_q;
      end
      A_CNT:    rd_val = cnt_q;
      default: begin
        for (int i = 0; i < N_CH; i++)
          if (addr_i == A_CC0 + ADDR_W'(i)) rd_val = cc_q[i];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       run_q,
  input logic                       cnt_tick,
  input logic                       wrap,
  input logic                       ovf_q,
  input logic                       we_i,
  input logic [cct_pkg::ADDR_W-1:0] addr_i,
  input logic [W-1:0]               wdata_i,
  input logic [W-1:0]               cnt_q,
  input logic [N-1:0]               irq_o,
  input logic [N-1:0]               tout_o
);
  logic ovf_clr;
  assign ovf_clr = we_i && (addr_i == cct_pkg::A_OPT) && !wdata_i[cct_pkg::OPT_OVF];

  a_r3_wrap_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_q);

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);

  a_r3_only_wrap_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_q && !wrap) |=> !ovf_q);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_tick |=> (!run_q || cnt_q == W'($past(cnt_q) + 1'b1)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cnt_tick) |=> (!run_q || $stable(cnt_q)));

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> (cnt_q == '0 && irq_o == '0 && tout_o == '0));

  for (genvar i = 0; i < N; i++) begin : g_a
    a_r4_toggle_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && $past(run_q) && tout_o[i] != $past(tout_o[i])) |-> irq_o[i]);
  end
endmodule

bind cct_timer cct_timer_chk #(.W(CNT_W), .N(N_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_q    (run_q),
  .cnt_tick (cnt_tick),
  .wrap     (wrap),
  .ovf_q    (ovf_q),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .cnt_q    (cnt_q),
  .irq_o    (irq_o),
  .tout_o   (tout_o)
);

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
module cct_timer_bench;
  localparam logic [2:0] R_CTRL = 3'd0, R_CAPSEL = 3'd1, R_EVTSEL = 3'd2,
                         R_OPT = 3'd3, R_CNT = 3'd4, R_CC0 = 3'd5, R_CC1 = 3'd6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  cap_i = '0;
  logic        evt_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  irq_o, tout_o;

  int total = 0;
  int bad = 0;
  logic rd_pend = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  cct_timer u_cct_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cap_i(cap_i), .evt_i(evt_i),
    .addr_i(addr_i), .we_i(we_i), .re_i(re_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .tout_o(tout_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_pend <= re_i;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard act=read exp=none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({16'h0, rdata_o}, {16'h0, e.exp}, e.tag);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    addr_i = a; re_i = 1'b1;
    @(negedge clk);
    re_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    cyc(n);
    tick_i = 1'b0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    check(rdata_o, 0, "R1 rdata");
    check(irq_o, 0, "R1 irq");
    check(tout_o, 0, "R1 tout");
    rd(R_CTRL, 16'h0, "R1 ctrl");
    rd(R_CNT, 16'h0, "R1 cnt");
    rd(R_OPT, 16'h0, "R1 opt");
    rd(3'd7, 16'h0, "R1 unused addr");

    // R4 compare on both channels, internal ticks
    wr(R_OPT, 16'h0000);
    wr(R_CC0, 16'd5);
    wr(R_CC1, 16'd9);
    rd(R_CC1, 16'd9, "R2 cc1 readback");
    tick_i = 1'b1;
    addr_i = R_CTRL; wdata_i = 16'h0001; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check(irq_o[0], k == 6, $sformatf("R4 ch0 irq k=%0d", k));
      check(irq_o[1], k == 10, $sformatf("R4 ch1 irq k=%0d", k));
      check(tout_o[0], k >= 6, $sformatf("R4 ch0 tout k=%0d", k));
      check(tout_o[1], k >= 10, $sformatf("R4 ch1 tout k=%0d", k));
      if (k == 12) tick_i = 1'b0;
    end
    rd(R_CNT, 16'd12, "R2 count held");

    // R9 run clear
    wr(R_CTRL, 16'h0000);
    cyc(1);
    check(tout_o, 0, "R9 tout low");
    check(irq_o, 0, "R9 irq low");
    rd(R_CNT, 16'h0, "R9 cnt zero");

    // R3 overflow with simultaneous clear, R4 at D=FFFF
    wr(R_CC0, 16'hFFFF);
    tick_i = 1'b1;
    addr_i = R_CTRL; wdata_i = 16'h0001; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
    for (int k = 1; k <= 65536; k++) begin
      @(negedge clk);
      if (k == 65535) begin
        check(irq_o[0], 0, "R4 no early match");
        addr_i = R_OPT; wdata_i = 16'h0000; we_i = 1'b1;
      end
      if (k == 65536) begin
        we_i = 1'b0;
        tick_i = 1'b0;
        check(irq_o[0], 1, "R4 match on wrap");
      end
    end
    rd(R_OPT, 16'h0001, "R3 wrap beats clear");
    rd(R_CNT, 16'h0000, "R2 wrapped to zero");
    cyc(5);
    rd(R_OPT, 16'h0001, "R3 sticky");
    wr(R_OPT, 16'h0001);
    rd(R_OPT, 16'h0001, "R3 write one no effect");
    wr(R_OPT, 16'h0000);
    rd(R_OPT, 16'h0000, "R3 cleared");

    // R5 R6 R7 capture
    ticks(7);
    wr(R_OPT, 16'h0030);
    wr(R_CAPSEL, 16'h0009);
    cap_i = 2'b11;
    cyc(2);
    check(irq_o, 0, "R5 no pulse before third edge");
    cyc(1);
    check(irq_o, 2'b01, "R5 R6 ch0 rising pulse, ch1 ignores rising");
    cyc(1);
    check(irq_o, 0, "R5 single cycle pulse");
    cyc(1);
    rd(R_CC0, 16'd7, "R5 ch0 captured");
    rd(R_CC1, 16'd9, "R6 ch1 unchanged on rising");
    ticks(4);
    cap_i = 2'b00;
    cyc(3);
    check(irq_o, 2'b10, "R6 ch1 falling pulse, ch0 ignores falling");
    cyc(2);
    rd(R_CC1, 16'd11, "R5 ch1 captured");
    rd(R_CC0, 16'd7, "R6 ch0 kept");

    // R10 read collides with capture
    ticks(5);
    wr(R_CAPSEL, 16'h000B);
    cap_i[0] = 1'b1;
    cyc(2);
    rd(R_CC0, 16'd7, "R10 old value on capture cycle");
    cyc(2);
    rd(R_CC0, 16'd16, "R10 new value after");

    // R6 edge select none
    wr(R_CAPSEL, 16'h0008);
    ticks(3);
    cap_i[0] = 1'b0;
    cyc(3);
    check(irq_o[0], 0, "R6 select none no pulse");
    cyc(1);
    rd(R_CC0, 16'd16, "R6 select none no capture");

    // R7 compare mode ignores capture pin
    wr(R_OPT, 16'h0020);
    wr(R_CAPSEL, 16'h000B);
    cap_i[0] = 1'b1;
    cyc(3);
    check(irq_o[0], 0, "R7 compare mode no capture pulse");
    cyc(1);
    rd(R_CC0, 16'd16, "R7 compare mode no capture");

    // R8 external event counting
    wr(R_EVTSEL, 16'h0001);
    wr(R_CTRL, 16'h0003);
    tick_i = 1'b1;
    evt_i = 1'b1; cyc(4);
    evt_i = 1'b0; cyc(4);
    evt_i = 1'b1; cyc(4);
    rd(R_CNT, 16'd21, "R8 rising events counted, tick ignored");
    wr(R_EVTSEL, 16'h0000);
    evt_i = 1'b0; cyc(4);
    evt_i = 1'b1; cyc(4);
    rd(R_CNT, 16'd21, "R8 R6 event select none");
    wr(R_EVTSEL, 16'h0003);
    evt_i = 1'b0; cyc(4);
    evt_i = 1'b1; cyc(4);
    rd(R_CNT, 16'd23, "R8 both edges counted");
    tick_i = 1'b0;

    cyc(3);
    summary();
  end
endmodule